// File: doc/BRIEF.md
# SDRAM Power-Up and Refresh Sequencer

This block handles SDRAM housekeeping for a memory controller. It leaves reset holding the clock enable high and driving no-operation commands through a long settling pause. It then runs the fixed bring-up order: one precharge of all banks, a set of auto-refresh commands and finally a mode-register load. Each command is spaced by the device recovery times, which are converted to clock counts by rounding up against a clock-period parameter. When the mode load has settled, the block flags itself initialised.

In normal operation a refresh timer raises a refresh request at the average interval the attached devices need. The interval is long for 4k-row parts and half as long for 8k-row parts. The main command arbiter answers with a grant. Refreshes that the arbiter holds off are counted, up to eight, and an urgent flag shows when that limit is reached. On request the block also puts the devices into self-refresh, with the clock enable low, and brings them out again. On exit it waits two clock edges and then a full row-cycle time before it allows any further command.

Top module: `sdram_upkeep_ctrl`

## Requirements
- R1: While `rst_ni` is low, `cmd_o` is 000 (no operation), `cke_o` is 1, and `init_done_o`, `ref_req_o` and `urgent_o` are 0. Command codes are 000 no-op, 001 precharge all, 010 auto-refresh, 011 mode-register load, 100 self-refresh entry.
- R2: After reset is released, the first command other than no-op is precharge-all (001). It appears in cycle ceil(PAUSE_PS/CLK_PS)+1, counting the cycle after the first rising edge as cycle 1.
- R3: Before `init_done_o` rises, the block issues exactly ten commands, in this order: one precharge-all, INIT_REFS (8) auto-refreshes, one mode-register load.
- R4: The command after a precharge-all follows it by exactly ceil(TRP_PS/CLK_PS) cycles during bring-up, and never by fewer.
- R5: The command after an auto-refresh follows it by at least ceil(TRC_PS/CLK_PS) cycles. The gap is exactly that value during bring-up and that value plus one when refreshes are granted back to back.
- R6: `init_done_o` rises exactly MRD_CLK (2) cycles after the mode-register load and then stays high until reset.
- R7: `ref_req_o` first rises exactly ceil(REFI/CLK_PS) cycles after `init_done_o` rises. REFI is REFI_4K_PS (15.6 us) when `dens_8k_i` is 0 and REFI_8K_PS (7.8 us) when it is 1. The timer keeps running while a request waits.
- R8: Up to MAX_POSTPONE (8) refresh intervals can expire without a grant. `urgent_o` rises in the cycle the eighth one is counted. Later expiries are dropped, so a grant afterwards drains exactly eight refreshes, and `urgent_o` falls after the first of them.
- R9: When `ref_req_o` and `grant_i` are both high at a rising edge, an auto-refresh is issued in the following cycle. A pending refresh takes priority over a self-refresh request that is granted at the same time.
- R10: With no refresh pending, a granted `sr_req_i` issues self-refresh entry (100) with `cke_o` low in the same cycle. While in self-refresh, `cmd_o` stays 000, `ref_req_o` stays 0 and the refresh timer is held.
- R11: When `sr_req_i` falls during self-refresh, `cke_o` rises in the next cycle. The next command comes no earlier than ceil(TRC_PS/CLK_PS)+2 cycles after that rise, and exactly then if it is requested and granted at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dens_8k_i | input | 1 | 1 selects the short refresh interval for 8k-row devices |
| sr_req_i | input | 1 | Request to enter and stay in self-refresh |
| grant_i | input | 1 | Arbiter grant for the pending housekeeping command |
| cmd_o | output | 3 | Command code driven to the devices |
| cke_o | output | 1 | Clock enable to the devices |
| ref_req_o | output | 1 | Service request to the arbiter (refresh pending or self-refresh wanted) |
| urgent_o | output | 1 | The postponed-refresh count is at its limit |
| init_done_o | output | 1 | Bring-up sequence finished |

## Verification
Bring-up runs once with each density setting. The full event list is checked each time, which separates a wrong pause, wrong ordering, a missing refresh and a wrong recovery gap. The refresh timer is measured against both interval lengths, so a swapped or unrounded interval shows up. Three grant patterns are used: an immediate grant, a grant withheld for nine intervals, and a grant raised together with a self-refresh request. These separate queue depth, saturation, drain spacing and refresh-over-self-refresh priority. Self-refresh is held for longer than one refresh interval, which shows that the timer is frozen, and it is re-entered as soon as allowed after exit, which pins the two-edge-plus-row-cycle wait.

// File: rtl/sdram_upkeep_pkg.sv
package sdram_upkeep_pkg;

  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_PREA = 3'd1,
    CMD_REF  = 3'd2,
    CMD_MRS  = 3'd3,
    CMD_SRE  = 3'd4
  } upk_cmd_e;

  typedef enum logic [3:0] {
    ST_PAUSE,
    ST_PREA_W,
    ST_INIT_REF,
    ST_MRS_W,
    ST_IDLE,
    ST_REF_W,
    ST_SR,
    ST_SR_EXIT
  } upk_state_e;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/upkeep_delay.sv
module upkeep_delay #(
  parameter int W       = 14,
  parameter int RST_VAL = 13334
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= W'(RST_VAL);
    else if (load_i)          cnt_q <= val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - W'(1);
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/upkeep_ref_timer.sv
module upkeep_ref_timer #(
  parameter int I4   = 2080,
  parameter int I8   = 1040,
  parameter int MAXP = 8,
  parameter int IW   = 12,
  parameter int PW   = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic dens_8k_i,
  input  logic take_i,
  output logic pend_nz_o,
  output logic urgent_o
);

  localparam logic [IW-1:0] RL4  = IW'(I4 - 1);
  localparam logic [IW-1:0] RL8  = IW'(I8 - 1);
  localparam logic [PW-1:0] PMAX = PW'(MAXP);

  logic [IW-1:0] cnt_q;
  logic [IW-1:0] reload;
  logic [PW-1:0] pend_q;
  logic          tick;
  logic          inc;

  assign reload = dens_8k_i ? RL8 : RL4;
  assign tick   = run_i && (cnt_q == '0);
  // expiries beyond the queue limit are dropped
  assign inc    = tick && (pend_q != PMAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pend_q <= '0;
    end else if (!run_i) begin
      cnt_q  <= reload;
      pend_q <= '0;
    end else begin
      cnt_q <= tick ? reload : cnt_q - IW'(1);
      if (inc && !take_i)      pend_q <= pend_q + PW'(1);
      else if (!inc && take_i) pend_q <= pend_q - PW'(1);
    end
  end

  assign pend_nz_o = (pend_q != '0);
  assign urgent_o  = (pend_q == PMAX);

  assert_pend_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q <= PMAX);

  assert_take_pending_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> (pend_q != '0));

  assert_urgent_reach_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && inc && !take_i && pend_q == PMAX - PW'(1)) |=> urgent_o);

endmodule

// File: rtl/upkeep_seq.sv
module upkeep_seq
  import sdram_upkeep_pkg::*;
#(
  parameter int PAUSE_CLK = 13334,
  parameter int TRP_CLK   = 3,
  parameter int TRC_CLK   = 9,
  parameter int MRD_CLK   = 2,
  parameter int INIT_REFS = 8,
  parameter int DW        = 14
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     sr_req_i,
  input  logic     grant_i,
  input  logic     pend_nz_i,
  output upk_cmd_e cmd_o,
  output logic     cke_o,
  output logic     init_done_o,
  output logic     req_o,
  output logic     take_o,
  output logic     run_o
);

  localparam int RW = $clog2(INIT_REFS + 1);
  localparam logic [DW-1:0] V_TRP  = DW'(TRP_CLK - 1);
  localparam logic [DW-1:0] V_TRC  = DW'(TRC_CLK - 1);
  localparam logic [DW-1:0] V_MRD  = DW'(MRD_CLK - 1);
  localparam logic [DW-1:0] V_SRX  = DW'(TRC_CLK);
  localparam logic [RW-1:0] N_INIT = RW'(INIT_REFS);

  upk_state_e    st_q, st_d;
  upk_cmd_e      cmd_q, cmd_d;
  logic          cke_q, cke_d;
  logic          done_q, done_d;
  logic [RW-1:0] nref_q, nref_d;
  logic          ld;
  logic [DW-1:0] ld_val;
  logic          dly_zero;

  upkeep_delay #(
    .W      (DW),
    .RST_VAL(PAUSE_CLK)
  ) u_dly (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(ld),
    .val_i (ld_val),
    .zero_o(dly_zero)
  );

  assign take_o = (st_q == ST_IDLE) && grant_i && pend_nz_i;

  always_comb begin
    st_d   = st_q;
    cmd_d  = CMD_NOP;
    cke_d  = cke_q;
    done_d = done_q;
    nref_d = nref_q;
    ld     = 1'b0;
    ld_val = '0;
    unique case (st_q)
      ST_PAUSE: if (dly_zero) begin
        cmd_d = CMD_PREA; ld = 1'b1; ld_val = V_TRP; st_d = ST_PREA_W;
      end
      ST_PREA_W: if (dly_zero) begin
        cmd_d = CMD_REF; ld = 1'b1; ld_val = V_TRC; nref_d = RW'(1); st_d = ST_INIT_REF;
      end
      ST_INIT_REF: if (dly_zero) begin
        ld = 1'b1;
        if (nref_q == N_INIT) begin
          cmd_d = CMD_MRS; ld_val = V_MRD; st_d = ST_MRS_W;
        end else begin
          cmd_d = CMD_REF; ld_val = V_TRC; nref_d = nref_q + RW'(1);
        end
      end
      ST_MRS_W: if (dly_zero) begin
        done_d = 1'b1; st_d = ST_IDLE;
      end
      ST_IDLE: begin
        if (take_o) begin
          cmd_d = CMD_REF; ld = 1'b1; ld_val = V_TRC; st_d = ST_REF_W;
        end else if (grant_i && sr_req_i) begin
          cmd_d = CMD_SRE; cke_d = 1'b0; st_d = ST_SR;
        end
      end
      ST_REF_W: if (dly_zero) st_d = ST_IDLE;
      ST_SR: if (!sr_req_i) begin
        // exit registers two edges after the clock enable rises, then one row cycle
        cke_d = 1'b1; ld = 1'b1; ld_val = V_SRX; st_d = ST_SR_EXIT;
      end
      ST_SR_EXIT: if (dly_zero) st_d = ST_IDLE;
      default: st_d = ST_PAUSE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_PAUSE;
      cmd_q  <= CMD_NOP;
      cke_q  <= 1'b1;
      done_q <= 1'b0;
      nref_q <= '0;
    end else begin
      st_q   <= st_d;
      cmd_q  <= cmd_d;
      cke_q  <= cke_d;
      done_q <= done_d;
      nref_q <= nref_d;
    end
  end

  assign cmd_o       = cmd_q;
  assign cke_o       = cke_q;
  assign init_done_o = done_q;
  assign req_o       = (st_q == ST_IDLE) && (pend_nz_i || sr_req_i);
  assign run_o       = (st_q == ST_IDLE) || (st_q == ST_REF_W);

  assert_grant_issue_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && grant_i && pend_nz_i) |=> (cmd_q == CMD_REF));

  assert_sr_no_req_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke_q) |-> !req_o);

endmodule

// File: rtl/sdram_upkeep_ctrl.sv
module sdram_upkeep_ctrl
  import sdram_upkeep_pkg::*;
#(
  parameter int CLK_PS       = 7500,
  parameter int PAUSE_PS     = 100_000_000,
  parameter int TRP_PS       = 20_000,
  parameter int TRC_PS       = 67_500,
  parameter int REFI_4K_PS   = 15_600_000,
  parameter int REFI_8K_PS   = 7_800_000,
  parameter int MRD_CLK      = 2,
  parameter int INIT_REFS    = 8,
  parameter int MAX_POSTPONE = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       dens_8k_i,
  input  logic       sr_req_i,
  input  logic       grant_i,
  output logic [2:0] cmd_o,
  output logic       cke_o,
  output logic       ref_req_o,
  output logic       urgent_o,
  output logic       init_done_o
);

  localparam int PAUSE_CLK = ceil_div(PAUSE_PS, CLK_PS);
  localparam int TRP_CLK   = ceil_div(TRP_PS, CLK_PS);
  localparam int TRC_CLK   = ceil_div(TRC_PS, CLK_PS);
  localparam int I4_CLK    = ceil_div(REFI_4K_PS, CLK_PS);
  localparam int I8_CLK    = ceil_div(REFI_8K_PS, CLK_PS);
  localparam int DW        = $clog2(max2(PAUSE_CLK, TRC_CLK) + 1);
  localparam int IW        = $clog2(max2(I4_CLK, I8_CLK) + 1);
  localparam int PW        = $clog2(MAX_POSTPONE + 1);

  upk_cmd_e cmd;
  logic     pend_nz, take, run, req, cke, done;

  upkeep_seq #(
    .PAUSE_CLK(PAUSE_CLK),
    .TRP_CLK  (TRP_CLK),
    .TRC_CLK  (TRC_CLK),
    .MRD_CLK  (MRD_CLK),
    .INIT_REFS(INIT_REFS),
    .DW       (DW)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sr_req_i   (sr_req_i),
    .grant_i    (grant_i),
    .pend_nz_i  (pend_nz),
    .cmd_o      (cmd),
    .cke_o      (cke),
    .init_done_o(done),
    .req_o      (req),
    .take_o     (take),
    .run_o      (run)
  );

  upkeep_ref_timer #(
    .I4  (I4_CLK),
    .I8  (I8_CLK),
    .MAXP(MAX_POSTPONE),
    .IW  (IW),
    .PW  (PW)
  ) u_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run),
    .dens_8k_i(dens_8k_i),
    .take_i   (take),
    .pend_nz_o(pend_nz),
    .urgent_o (urgent_o)
  );

  assign cmd_o       = cmd;
  assign cke_o       = cke;
  assign ref_req_o   = req;
  assign init_done_o = done;

  // command-spacing observer for the assertions below
  localparam int GW = $clog2(PAUSE_CLK + TRC_CLK + 4);
  localparam int RW = $clog2(INIT_REFS + 2);
  localparam logic [GW-1:0] G_PAUSE = GW'(PAUSE_CLK);
  localparam logic [GW-1:0] G_TRP   = GW'(TRP_CLK);
  localparam logic [GW-1:0] G_TRC   = GW'(TRC_CLK);
  localparam logic [GW-1:0] G_SRX   = GW'(TRC_CLK + 2);
  localparam logic [RW-1:0] N_INIT  = RW'(INIT_REFS);

  logic [GW-1:0] gap_q;
  upk_cmd_e      last_q;
  logic [RW-1:0] obs_refs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q      <= '0;
      last_q     <= CMD_NOP;
      obs_refs_q <= '0;
    end else if (cmd != CMD_NOP) begin
      gap_q  <= GW'(1);
      last_q <= cmd;
      if (cmd == CMD_PREA)                          obs_refs_q <= '0;
      else if (cmd == CMD_REF && obs_refs_q != '1) obs_refs_q <= obs_refs_q + RW'(1);
    end else if (gap_q != '1) begin
      gap_q <= gap_q + GW'(1);
    end
  end

  assert_pause_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd != CMD_NOP && last_q == CMD_NOP) |-> (cmd == CMD_PREA && gap_q >= G_PAUSE));

  assert_mrs_order_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == CMD_MRS) |-> (last_q == CMD_REF && obs_refs_q == N_INIT && !done));

  assert_trp_gap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd != CMD_NOP && last_q == CMD_PREA) |-> (gap_q >= G_TRP));

  assert_trc_gap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd != CMD_NOP && last_q == CMD_REF) |-> (gap_q >= G_TRC));

  assert_done_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> done);

  assert_cke_nop_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke) |=> (cmd == CMD_NOP));

  assert_sr_exit_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd != CMD_NOP && last_q == CMD_SRE) |-> (gap_q >= G_SRX));

endmodule

// File: tb/test_sdram_upkeep_ctrl.sv
module test_sdram_upkeep_ctrl;

  localparam int CLK_PS = 10000;
  localparam int P   = (100_000_000 + CLK_PS - 1) / CLK_PS;
  localparam int TRP = (20_000 + CLK_PS - 1) / CLK_PS;
  localparam int TRC = (67_500 + CLK_PS - 1) / CLK_PS;
  localparam int MRD = 2;
  localparam int I4  = (15_600_000 + CLK_PS - 1) / CLK_PS;
  localparam int I8  = (7_800_000 + CLK_PS - 1) / CLK_PS;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       dens_8k_i = 1'b0;
  logic       sr_req_i = 1'b0;
  logic       grant_i = 1'b0;
  logic [2:0] cmd_o;
  logic       cke_o, ref_req_o, urgent_o, init_done_o;

  int n_chk = 0;
  int n_fail = 0;
  int t = 0;
  bit ended = 1'b0;

  sdram_upkeep_ctrl #(.CLK_PS(CLK_PS)) i_sdram_upkeep_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .dens_8k_i  (dens_8k_i),
    .sr_req_i   (sr_req_i),
    .grant_i    (grant_i),
    .cmd_o      (cmd_o),
    .cke_o      (cke_o),
    .ref_req_o  (ref_req_o),
    .urgent_o   (urgent_o),
    .init_done_o(init_done_o)
  );

  always #5 clk_i = ~clk_i;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (t=%0d)", rq, act, exp, t);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic step();
    @(negedge clk_i);
    t++;
  endtask

  // R1: reset values
  task automatic do_reset(input logic dens);
    int act;
    rst_ni = 1'b0; grant_i = 1'b0; sr_req_i = 1'b0; dens_8k_i = dens;
    repeat (3) @(negedge clk_i);
    act = {cmd_o, cke_o, init_done_o, ref_req_o, urgent_o};
    chk(act == 8, "R1", act, 8);
    rst_ni = 1'b1;
    t = 0;
  endtask

  // R2..R6: bring-up event list
  task automatic run_init(output int t_done);
    int ev_t [12];
    int ev_c [12];
    int n = 0;
    t_done = -1;
    while (t < P + 200) begin
      step();
      if (cmd_o != 3'd0) begin
        if (n < 12) begin ev_t[n] = t; ev_c[n] = int'(cmd_o); end
        n++;
      end
      if (init_done_o) begin t_done = t; break; end
    end
    chk(n == 10, "R3", n, 10);
    if (n == 10) begin
      chk(ev_c[0] == 1, "R2", ev_c[0], 1);
      chk(ev_t[0] == P + 1, "R2", ev_t[0], P + 1);
      chk(ev_t[1] - ev_t[0] == TRP, "R4", ev_t[1] - ev_t[0], TRP);
      for (int i = 1; i <= 8; i++) chk(ev_c[i] == 2, "R3", ev_c[i], 2);
      for (int i = 2; i <= 9; i++) chk(ev_t[i] - ev_t[i-1] == TRC, "R5", ev_t[i] - ev_t[i-1], TRC);
      chk(ev_c[9] == 3, "R3", ev_c[9], 3);
      chk(t_done - ev_t[9] == MRD, "R6", t_done - ev_t[9], MRD);
    end
  endtask

  // R7: interval from init_done to first request
  task automatic wait_req(input int iv);
    int k = 0;
    while (!ref_req_o && k < iv + 50) begin
      step();
      k++;
      if (!init_done_o) chk(1'b0, "R6", 0, 1);
    end
    chk(k == iv, "R7", k, iv);
  endtask

  // R9 priority, R10 entry/hold, R11 exit spacing
  task automatic sr_scenario();
    int k;
    int bad = 0;
    grant_i = 1'b1; sr_req_i = 1'b1;
    step();
    chk(cmd_o == 3'd2, "R9", int'(cmd_o), 2);
    k = 0;
    do begin step(); k++; end while (cmd_o == 3'd0 && k < 50);
    chk(cmd_o == 3'd4 && k == TRC + 1, "R10", k, TRC + 1);
    chk(cke_o == 1'b0, "R10", int'(cke_o), 0);
    grant_i = 1'b0;
    repeat (I4 + 20) begin
      step();
      if (cmd_o != 3'd0 || ref_req_o || cke_o) bad++;
    end
    chk(bad == 0, "R10", bad, 0);
    sr_req_i = 1'b0;
    step();
    chk(cke_o == 1'b1, "R11", int'(cke_o), 1);
    sr_req_i = 1'b1; grant_i = 1'b1;
    k = 0;
    do begin step(); k++; end while (cmd_o == 3'd0 && k < 50);
    chk(cmd_o == 3'd4 && k == TRC + 2, "R11", k, TRC + 2);
    sr_req_i = 1'b0; grant_i = 1'b0;
    step();
    chk(cke_o == 1'b1, "R11", int'(cke_o), 1);
  endtask

  // R8: queue fill, saturation and drain
  task automatic postpone_scenario(input int d);
    int nref = 0;
    int last = -1;
    int first_t = -1;
    int badgap = 0;
    int t_g;
    grant_i = 1'b0;
    while (t < d + 8 * I8 - 1) step();
    chk(urgent_o == 1'b0, "R8", int'(urgent_o), 0);
    step();
    chk(urgent_o == 1'b1, "R8", int'(urgent_o), 1);
    while (t < d + 9 * I8 + 3) step();
    chk(urgent_o == 1'b1, "R8", int'(urgent_o), 1);
    grant_i = 1'b1;
    t_g = t;
    repeat (8 * (TRC + 1) + 20) begin
      step();
      if (cmd_o == 3'd2) begin
        if (first_t < 0) begin
          first_t = t;
          chk(urgent_o == 1'b0, "R8", int'(urgent_o), 0);
        end else if (t - last != TRC + 1) begin
          badgap++;
        end
        last = t;
        nref++;
      end
    end
    chk(first_t - t_g == 1, "R9", first_t - t_g, 1);
    chk(nref == 8, "R8", nref, 8);
    chk(badgap == 0, "R5", badgap, 0);
    grant_i = 1'b0;
  endtask

  initial begin
    int td;
    do_reset(1'b0);
    run_init(td);
    wait_req(I4);
    sr_scenario();
    do_reset(1'b1);
    run_init(td);
    wait_req(I8);
    postpone_scenario(td);
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

endmodule